// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block moves the CPU context of an 8-bit processor between its live registers and a descending stack in memory, one byte per clock over a byte-wide memory port. An entry command writes a five-byte frame: the program counter (low byte first), the low index byte, the accumulator and the condition code byte. It then sets the interrupt mask bit in the live condition code byte. A return command reads the same frame back in the opposite order. It then reads three program bytes from the restored program counter onward to refill the instruction pipeline. A small priority picker reports the most urgent pending request whenever the mask bit is clear. The request chosen at the moment an entry begins is held for the vector logic that follows.

The stack pointer always addresses the next free byte. A push writes at the pointer and then decrements it. A pull first increments the pointer and then reads. Reads return data in the same cycle the read strobe is high, so the port needs a zero-wait memory. The live registers are loaded through a load strobe and are always visible on observe ports. The upper index byte is not part of this block and never appears on the bus.

The controller has the states IDLE, PUSH_PCL, PUSH_PCH, PUSH_X, PUSH_A, PUSH_CCR, PULL_CCR, PULL_A, PULL_X, PULL_PCH, PULL_PCL, FETCH0, FETCH1 and FETCH2. The transitions are:
- IDLE goes to PUSH_PCL on an entry command. Otherwise it goes to PULL_CCR on a return command.
- The push states run in a chain: PUSH_PCL, PUSH_PCH, PUSH_X, PUSH_A, PUSH_CCR, then back to IDLE.
- The pull states run in a chain: PULL_CCR, PULL_A, PULL_X, PULL_PCH, PULL_PCL, then on to the fetch states.
- The fetch states run FETCH0, FETCH1, FETCH2, then back to IDLE.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset the block is idle:
  - `busy`, `done`, `mem_wr` and `mem_rd` are 0.
  - `sp_q` is 0x00FF.
  - `ccr_q` is 0x08, meaning the mask bit (bit 3) is set.
  - `pc_q` is 0x0000.
- R2: An entry makes exactly five write cycles on consecutive clocks, with no read. With S the stack pointer before entry, the writes are:
  - address S: PC bits 7:0
  - address S-1: PC bits 15:8
  - address S-2: index low byte
  - address S-3: accumulator
  - address S-4: condition code byte
- R3: After an entry the stack pointer equals S-5, one below the address of the stacked condition code byte.
- R4: The stacked condition code byte holds its value from before entry. After entry the live `ccr_q` has bit 3 set and all other bits unchanged. PC, X and A are unchanged.
- R5: A return makes five reads at SP+1 through SP+5. These load, in order, the condition code byte, the accumulator, the index low byte, PC bits 15:8 and PC bits 7:0. The stack pointer ends at SP+5.
- R6: After the PC is restored, three reads follow at PC, PC+1 and PC+2. The bytes read land in `fill_q` bits 7:0, 15:8 and 23:16 respectively. `pc_q` keeps the restored value.
- R7: `busy` is high in every sequence cycle. `done` is high for exactly one cycle, the cycle after the last memory access, with `busy` low. That cycle is the 6th after an entry command is sampled and the 9th after a return command is sampled.
- R8: While `busy` is high, `entry_start`, `ret_start` and `ld_regs` have no effect on the bus, the registers or the sequence length.
- R9: The stack pointer and the addresses it forms wrap modulo 2^16 on both decrement and increment.
- R10: Request selection:
  - `req_valid` is 1 exactly when some `irq_pend` bit is set and `ccr_q` bit 3 is clear.
  - `req_idx` is the lowest set bit index.
  - `svc_idx` captures `req_idx` when an entry command is accepted.
- R11: If `entry_start` and `ret_start` are both high in IDLE, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_start | input | 1 | Begin interrupt entry (sampled in IDLE) |
| ret_start | input | 1 | Begin return from interrupt (sampled in IDLE) |
| ld_regs | input | 1 | Load live registers from the *_in ports (idle only) |
| pc_in | input | 16 | Program counter load value |
| x_in | input | 8 | Index low byte load value |
| a_in | input | 8 | Accumulator load value |
| ccr_in | input | 8 | Condition code load value |
| sp_in | input | 16 | Stack pointer load value |
| irq_pend | input | 8 | Pending request lines, bit 0 most urgent |
| mem_rdata | input | 8 | Read data, valid in the cycle of mem_rd |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| pc_q | output | 16 | Live program counter |
| x_q | output | 8 | Live index low byte |
| a_q | output | 8 | Live accumulator |
| ccr_q | output | 8 | Live condition code byte |
| sp_q | output | 16 | Live stack pointer |
| fill_q | output | 24 | Three refill bytes, PC+0 in bits 7:0 |
| req_valid | output | 1 | An unmasked request is pending |
| req_idx | output | 3 | Index of the most urgent pending request |
| svc_idx | output | 3 | Request index captured at entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Entry and return are run with a mid-memory stack pointer and with one two bytes above zero. The second case separates correct modulo-2^16 wrap from a truncated or saturating pointer, and checks that the refill address runs independently of the stack. Every frame value is distinct, so any swap of push or pull order shows up as an address or data miscompare. A clear mask in the stacked byte tells the stacked copy apart from the masked live value. Start and load strobes injected mid-sequence, and simultaneous entry and return commands, separate correct ignoring and precedence from restarts or extra bus cycles. Pending patterns with several bits set tell lowest-index priority apart from highest-index priority.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    localparam int NFILL = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_X,
        ST_PUSH_A,
        ST_PUSH_CCR,
        ST_PULL_CCR,
        ST_PULL_A,
        ST_PULL_X,
        ST_PULL_PCH,
        ST_PULL_PCL,
        ST_FETCH0,
        ST_FETCH1,
        ST_FETCH2
    } seq_state_t;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_PCL,
        FLD_PCH,
        FLD_X,
        FLD_A,
        FLD_CCR
    } ctx_field_t;

    typedef enum logic [1:0] {
        AD_SP,
        AD_SP_NEXT,
        AD_PC
    } addr_src_t;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NREQ = 8,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] pend,
    input  logic            mask,
    output logic            valid,
    output logic [IW-1:0]   idx
);

    // Lowest set index wins: scan from the top so lower indices overwrite.
    always_comb begin
        idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign valid = (|pend) && !mask;

endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm
    import irq_ctx_pkg::*;
#(
    parameter int NREQ = 8,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int FW = $clog2(NFILL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          entry_start,
    input  logic          ret_start,
    input  logic [IW-1:0] pick_idx,
    output seq_state_t    state,
    output ctx_field_t    field,
    output addr_src_t     addr_src,
    output logic [FW-1:0] fetch_ofs,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic          sp_dec,
    output logic          sp_inc,
    output logic          set_imask,
    output logic          pipe_we,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] svc_idx
);

    seq_state_t state_nx;

    // State register, completion pulse and captured request index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            svc_idx <= '0;
        end else begin
            state <= state_nx;
            done  <= (state == ST_PUSH_CCR) || (state == ST_FETCH2);
            if ((state == ST_IDLE) && entry_start) begin
                svc_idx <= pick_idx;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (entry_start) begin
                    state_nx = ST_PUSH_PCL;
                end else if (ret_start) begin
                    state_nx = ST_PULL_CCR;
                end
            end
            ST_PUSH_PCL: state_nx = ST_PUSH_PCH;
            ST_PUSH_PCH: state_nx = ST_PUSH_X;
            ST_PUSH_X:   state_nx = ST_PUSH_A;
            ST_PUSH_A:   state_nx = ST_PUSH_CCR;
            ST_PUSH_CCR: state_nx = ST_IDLE;
            ST_PULL_CCR: state_nx = ST_PULL_A;
            ST_PULL_A:   state_nx = ST_PULL_X;
            ST_PULL_X:   state_nx = ST_PULL_PCH;
            ST_PULL_PCH: state_nx = ST_PULL_PCL;
            ST_PULL_PCL: state_nx = ST_FETCH0;
            ST_FETCH0:   state_nx = ST_FETCH1;
            ST_FETCH1:   state_nx = ST_FETCH2;
            ST_FETCH2:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        field     = FLD_NONE;
        addr_src  = AD_SP;
        fetch_ofs = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        set_imask = 1'b0;
        pipe_we   = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_PUSH_PCL: begin mem_wr = 1'b1; sp_dec = 1'b1; field = FLD_PCL; end
            ST_PUSH_PCH: begin mem_wr = 1'b1; sp_dec = 1'b1; field = FLD_PCH; end
            ST_PUSH_X:   begin mem_wr = 1'b1; sp_dec = 1'b1; field = FLD_X;   end
            ST_PUSH_A:   begin mem_wr = 1'b1; sp_dec = 1'b1; field = FLD_A;   end
            ST_PUSH_CCR: begin
                mem_wr    = 1'b1;
                sp_dec    = 1'b1;
                field     = FLD_CCR;
                set_imask = 1'b1;
            end
            ST_PULL_CCR: begin mem_rd = 1'b1; sp_inc = 1'b1; addr_src = AD_SP_NEXT; field = FLD_CCR; end
            ST_PULL_A:   begin mem_rd = 1'b1; sp_inc = 1'b1; addr_src = AD_SP_NEXT; field = FLD_A;   end
            ST_PULL_X:   begin mem_rd = 1'b1; sp_inc = 1'b1; addr_src = AD_SP_NEXT; field = FLD_X;   end
            ST_PULL_PCH: begin mem_rd = 1'b1; sp_inc = 1'b1; addr_src = AD_SP_NEXT; field = FLD_PCH; end
            ST_PULL_PCL: begin mem_rd = 1'b1; sp_inc = 1'b1; addr_src = AD_SP_NEXT; field = FLD_PCL; end
            ST_FETCH0: begin mem_rd = 1'b1; pipe_we = 1'b1; addr_src = AD_PC; fetch_ofs = FW'(0); end
            ST_FETCH1: begin mem_rd = 1'b1; pipe_we = 1'b1; addr_src = AD_PC; fetch_ofs = FW'(1); end
            ST_FETCH2: begin mem_rd = 1'b1; pipe_we = 1'b1; addr_src = AD_PC; fetch_ofs = FW'(2); end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctx_regs.sv
module ctx_regs
    import irq_ctx_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          IBIT    = 3,
    parameter logic [15:0] SP_RST  = 16'h00FF,
    parameter logic [7:0]  CCR_RST = 8'h08,
    localparam int AW = 2 * DW,
    localparam int FW = $clog2(NFILL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [AW-1:0]     pc_in,
    input  logic [DW-1:0]     x_in,
    input  logic [DW-1:0]     a_in,
    input  logic [DW-1:0]     ccr_in,
    input  logic [AW-1:0]     sp_in,
    input  ctx_field_t        field,
    input  addr_src_t         addr_src,
    input  logic [FW-1:0]     fetch_ofs,
    input  logic              mem_rd,
    input  logic              sp_dec,
    input  logic              sp_inc,
    input  logic              set_imask,
    input  logic              pipe_we,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     pc_q,
    output logic [DW-1:0]     x_q,
    output logic [DW-1:0]     a_q,
    output logic [DW-1:0]     ccr_q,
    output logic [AW-1:0]     sp_q,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [NFILL*DW-1:0] fill_q
);

    logic pull_ld;
    assign pull_ld = mem_rd && (addr_src == AD_SP_NEXT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            x_q   <= '0;
            a_q   <= '0;
            ccr_q <= DW'(CCR_RST);
            sp_q  <= AW'(SP_RST);
        end else if (ld_en) begin
            pc_q  <= pc_in;
            x_q   <= x_in;
            a_q   <= a_in;
            ccr_q <= ccr_in;
            sp_q  <= sp_in;
        end else begin
            if (sp_dec) begin
                sp_q <= sp_q - 1'b1;
            end else if (sp_inc) begin
                sp_q <= sp_q + 1'b1;
            end
            if (set_imask) begin
                ccr_q[IBIT] <= 1'b1;
            end
            if (pull_ld) begin
                unique case (field)
                    FLD_PCL: pc_q[DW-1:0]  <= mem_rdata;
                    FLD_PCH: pc_q[AW-1:DW] <= mem_rdata;
                    FLD_X:   x_q           <= mem_rdata;
                    FLD_A:   a_q           <= mem_rdata;
                    FLD_CCR: ccr_q         <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end

    // Refill slots, one register per byte.
    for (genvar g = 0; g < NFILL; g++) begin : g_fill
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fill_q[g*DW +: DW] <= '0;
            end else if (pipe_we && (fetch_ofs == FW'(g))) begin
                fill_q[g*DW +: DW] <= mem_rdata;
            end
        end
    end

    always_comb begin
        unique case (field)
            FLD_PCL: mem_wdata = pc_q[DW-1:0];
            FLD_PCH: mem_wdata = pc_q[AW-1:DW];
            FLD_X:   mem_wdata = x_q;
            FLD_A:   mem_wdata = a_q;
            FLD_CCR: mem_wdata = ccr_q;
            default: mem_wdata = '0;
        endcase
    end

    always_comb begin
        unique case (addr_src)
            AD_SP:      mem_addr = sp_q;
            AD_SP_NEXT: mem_addr = sp_q + 1'b1;
            AD_PC:      mem_addr = pc_q + AW'(fetch_ofs);
            default:    mem_addr = sp_q;
        endcase
    end

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREQ = 8,
    parameter int IBIT = 3,
    localparam int AW = 2 * DW,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int FW = $clog2(NFILL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                entry_start,
    input  logic                ret_start,
    input  logic                ld_regs,
    input  logic [AW-1:0]       pc_in,
    input  logic [DW-1:0]       x_in,
    input  logic [DW-1:0]       a_in,
    input  logic [DW-1:0]       ccr_in,
    input  logic [AW-1:0]       sp_in,
    input  logic [NREQ-1:0]     irq_pend,
    input  logic [DW-1:0]       mem_rdata,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_wr,
    output logic                mem_rd,
    output logic [AW-1:0]       pc_q,
    output logic [DW-1:0]       x_q,
    output logic [DW-1:0]       a_q,
    output logic [DW-1:0]       ccr_q,
    output logic [AW-1:0]       sp_q,
    output logic [NFILL*DW-1:0] fill_q,
    output logic                req_valid,
    output logic [IW-1:0]       req_idx,
    output logic [IW-1:0]       svc_idx,
    output logic                busy,
    output logic                done
);

    seq_state_t    state;
    ctx_field_t    field;
    addr_src_t     addr_src;
    logic [FW-1:0] fetch_ofs;
    logic          sp_dec;
    logic          sp_inc;
    logic          set_imask;
    logic          pipe_we;
    logic          ld_en;

    assign ld_en = ld_regs && !busy;

    irq_pick #(.NREQ(NREQ)) u_pick (
        .pend  (irq_pend),
        .mask  (ccr_q[IBIT]),
        .valid (req_valid),
        .idx   (req_idx)
    );

    ctx_fsm #(.NREQ(NREQ)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_start (entry_start),
        .ret_start   (ret_start),
        .pick_idx    (req_idx),
        .state       (state),
        .field       (field),
        .addr_src    (addr_src),
        .fetch_ofs   (fetch_ofs),
        .mem_wr      (mem_wr),
        .mem_rd      (mem_rd),
        .sp_dec      (sp_dec),
        .sp_inc      (sp_inc),
        .set_imask   (set_imask),
        .pipe_we     (pipe_we),
        .busy        (busy),
        .done        (done),
        .svc_idx     (svc_idx)
    );

    ctx_regs #(.DW(DW), .IBIT(IBIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .ccr_in    (ccr_in),
        .sp_in     (sp_in),
        .field     (field),
        .addr_src  (addr_src),
        .fetch_ofs (fetch_ofs),
        .mem_rd    (mem_rd),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc),
        .set_imask (set_imask),
        .pipe_we   (pipe_we),
        .mem_rdata (mem_rdata),
        .pc_q      (pc_q),
        .x_q       (x_q),
        .a_q       (a_q),
        .ccr_q     (ccr_q),
        .sp_q      (sp_q),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fill_q    (fill_q)
    );

endmodule

// File: rtl/irq_ctx_seq_chk.sv
module irq_ctx_seq_chk
    import irq_ctx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREQ = 8,
    parameter int IBIT = 3,
    localparam int AW = 2 * DW,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input seq_state_t      state,
    input logic            mem_wr,
    input logic            mem_rd,
    input logic [AW-1:0]   sp_q,
    input logic [DW-1:0]   ccr_q,
    input logic            busy,
    input logic            done,
    input logic [NREQ-1:0] irq_pend,
    input logic            req_valid,
    input logic [IW-1:0]   req_idx
);

    // R2: never read and write in the same cycle
    p_bus_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R3: each push leaves the pointer one lower
    p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_q == $past(sp_q) - 1'b1));

    // R5: each pull leaves the pointer one higher
    p_pull_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_PULL_CCR, ST_PULL_A, ST_PULL_X, ST_PULL_PCH, ST_PULL_PCL})
        |=> (sp_q == $past(sp_q) + 1'b1));

    // R4: mask bit set once the condition code byte is pushed
    p_imask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_CCR) |=> ccr_q[IBIT]);

    // R7: completion is a single-cycle pulse while idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: selected request is pending and no lower index is pending
    p_pick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (irq_pend[req_idx] &&
                       ((irq_pend & ~({NREQ{1'b1}} << req_idx)) == '0)));
    p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_q[IBIT] |-> !req_valid);

endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.DW(DW), .NREQ(NREQ), .IBIT(IBIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .sp_q      (sp_q),
    .ccr_q     (ccr_q),
    .busy      (busy),
    .done      (done),
    .irq_pend  (irq_pend),
    .req_valid (req_valid),
    .req_idx   (req_idx)
);

// File: tb/irq_ctx_seq_tb.sv
`timescale 1ns/1ps
module irq_ctx_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_start = 1'b0;
    logic        ret_start = 1'b0;
    logic        ld_regs = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0;
    logic [7:0]  a_in = '0;
    logic [7:0]  ccr_in = '0;
    logic [15:0] sp_in = '0;
    logic [7:0]  irq_pend = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_wr, mem_rd;
    logic [15:0] pc_q, sp_q;
    logic [7:0]  x_q, a_q, ccr_q;
    logic [23:0] fill_q;
    logic        req_valid, busy, done;
    logic [2:0]  req_idx, svc_idx;

    always #2.5 clk = ~clk;

    irq_ctx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .entry_start(entry_start), .ret_start(ret_start),
        .ld_regs(ld_regs), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
        .sp_in(sp_in), .irq_pend(irq_pend), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd), .pc_q(pc_q), .x_q(x_q),
        .a_q(a_q), .ccr_q(ccr_q), .sp_q(sp_q), .fill_q(fill_q), .req_valid(req_valid),
        .req_idx(req_idx), .svc_idx(svc_idx), .busy(busy), .done(done)
    );

    // Bench memory: 256 bytes indexed by the low address byte.
    logic [7:0] mem [0:255];
    function automatic logic [7:0] pat(logic [7:0] a);
        return a ^ 8'h5A;
    endfunction
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
        end else if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr[7:0]];

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard of expected bus cycles.
    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } bus_t;
    bus_t exp_q[$];

    task automatic exp_push(bit wr, logic [15:0] a, logic [7:0] d, string tag);
        bus_t e;
        e.wr = wr; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && (mem_wr || mem_rd)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R8 unexpected bus cycle", {15'b0, mem_wr, mem_addr}, 32'h0);
            end else begin
                bus_t e;
                e = exp_q.pop_front();
                chk((mem_wr == e.wr) && (mem_addr == e.addr) && (!e.wr || mem_wdata == e.data),
                    e.tag, {7'b0, mem_wr, mem_addr, mem_wdata},
                    {7'b0, e.wr, e.addr, e.data});
            end
        end
    end

    // Bench model of the live registers.
    logic [15:0] m_pc, m_sp;
    logic [7:0]  m_x, m_a, m_ccr;

    task automatic load(logic [15:0] pc, logic [7:0] x, logic [7:0] a,
                        logic [7:0] ccr, logic [15:0] sp);
        @(negedge clk);
        ld_regs = 1'b1; pc_in = pc; x_in = x; a_in = a; ccr_in = ccr; sp_in = sp;
        @(negedge clk);
        ld_regs = 1'b0;
        m_pc = pc; m_x = x; m_a = a; m_ccr = ccr; m_sp = sp;
    endtask

    // Entry; optional mid-sequence noise on starts and load (R8).
    task automatic do_entry(bit also_ret, bit noise);
        int cyc;
        exp_push(1'b1, m_sp,          m_pc[7:0],  "R2 push PCL");
        exp_push(1'b1, m_sp - 16'd1,  m_pc[15:8], "R2 push PCH");
        exp_push(1'b1, m_sp - 16'd2,  m_x,        "R2 push X");
        exp_push(1'b1, m_sp - 16'd3,  m_a,        "R2 push A");
        exp_push(1'b1, m_sp - 16'd4,  m_ccr,      "R4 push CCR pre-mask");
        @(negedge clk);
        entry_start = 1'b1; ret_start = also_ret;
        @(negedge clk);
        entry_start = 1'b0; ret_start = 1'b0;
        chk(busy == 1'b1, "R7 busy in entry", {31'b0, busy}, 32'd1);
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (noise && cyc == 2) begin
                entry_start = 1'b1; ret_start = 1'b1; ld_regs = 1'b1;
                pc_in = 16'hFFFF; sp_in = 16'h0000; x_in = 8'hFF; a_in = 8'hFF; ccr_in = 8'hFF;
            end else if (noise && cyc == 3) begin
                entry_start = 1'b0; ret_start = 1'b0; ld_regs = 1'b0;
            end
        end
        chk(cyc == 6, "R7 entry done cycle", cyc, 6);
        chk(busy == 1'b0, "R7 idle at done", {31'b0, busy}, 32'd0);
        chk(exp_q.size() == 0, "R2 five writes", exp_q.size(), 0);
        m_sp  = m_sp - 16'd5;
        m_ccr = m_ccr | 8'h08;
        chk(sp_q == m_sp, "R3 sp after entry", sp_q, m_sp);
        chk(ccr_q == m_ccr, "R4 live ccr masked", ccr_q, m_ccr);
        chk({pc_q, x_q, a_q} == {m_pc, m_x, m_a}, "R4/R8 regs unchanged",
            {pc_q[7:0], x_q, a_q}, {m_pc[7:0], m_x, m_a});
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7/R8 single pulse, no restart",
            {30'b0, done, busy}, 32'd0);
    endtask

    task automatic do_return(logic [15:0] s_pc, logic [7:0] s_x, logic [7:0] s_a,
                             logic [7:0] s_ccr);
        int cyc;
        logic [23:0] efill;
        exp_push(1'b0, m_sp + 16'd1, 8'h00, "R5 pull CCR");
        exp_push(1'b0, m_sp + 16'd2, 8'h00, "R5 pull A");
        exp_push(1'b0, m_sp + 16'd3, 8'h00, "R5 pull X");
        exp_push(1'b0, m_sp + 16'd4, 8'h00, "R5 pull PCH");
        exp_push(1'b0, m_sp + 16'd5, 8'h00, "R5 pull PCL");
        exp_push(1'b0, s_pc,          8'h00, "R6 fetch +0");
        exp_push(1'b0, s_pc + 16'd1,  8'h00, "R6 fetch +1");
        exp_push(1'b0, s_pc + 16'd2,  8'h00, "R6 fetch +2");
        efill = {pat(8'(s_pc + 16'd2)), pat(8'(s_pc + 16'd1)), pat(s_pc[7:0])};
        @(negedge clk);
        ret_start = 1'b1;
        @(negedge clk);
        ret_start = 1'b0;
        chk(busy == 1'b1, "R7 busy in return", {31'b0, busy}, 32'd1);
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 9, "R7 return done cycle", cyc, 9);
        chk(exp_q.size() == 0, "R5 eight reads", exp_q.size(), 0);
        m_sp = m_sp + 16'd5;
        m_pc = s_pc; m_x = s_x; m_a = s_a; m_ccr = s_ccr;
        chk(sp_q == m_sp, "R5/R9 sp after return", sp_q, m_sp);
        chk({pc_q, x_q, a_q, ccr_q} == {s_pc, s_x, s_a, s_ccr}, "R5 regs restored",
            {pc_q, x_q, a_q}, {s_pc, s_x, s_a});
        chk(fill_q == efill, "R6 refill bytes", fill_q, efill);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, mem_wr, mem_rd} == 4'b0, "R1 idle strobes", {busy, done, mem_wr, mem_rd}, 0);
        chk(sp_q == 16'h00FF, "R1 sp reset", sp_q, 16'h00FF);
        chk(ccr_q == 8'h08, "R1 ccr reset", ccr_q, 8'h08);
        chk(pc_q == 16'h0000, "R1 pc reset", pc_q, 0);
        chk(req_valid == 1'b0, "R10 masked at reset", req_valid, 0);

        // Mid-memory entry with noise, priority pick
        irq_pend = 8'b0000_0110;
        load(16'h1234, 8'h56, 8'h78, 8'h00, 16'h0080);
        chk(req_valid == 1'b1 && req_idx == 3'd1, "R10 lowest index pick",
            {req_valid, req_idx}, {1'b1, 3'd1});
        do_entry(1'b0, 1'b1);
        chk(svc_idx == 3'd1, "R10 svc captured", svc_idx, 1);
        chk(req_valid == 1'b0, "R10 masked after entry", req_valid, 0);

        // Scramble live state, then return
        load(16'h0000, 8'h00, 8'h00, 8'h08, m_sp);
        do_return(16'h1234, 8'h56, 8'h78, 8'h00);
        chk(req_valid == 1'b1, "R10 unmasked after return", req_valid, 1);

        // Wrap through zero (R9)
        load(16'hBEEF, 8'h11, 8'h22, 8'h01, 16'h0002);
        do_entry(1'b0, 1'b0);
        chk(sp_q == 16'hFFFD, "R9 wrap on push", sp_q, 16'hFFFD);
        load(16'h0000, 8'h00, 8'h00, 8'h08, m_sp);
        do_return(16'hBEEF, 8'h11, 8'h22, 8'h01);
        chk(sp_q == 16'h0002, "R9 wrap on pull", sp_q, 16'h0002);

        // Simultaneous commands: entry wins (R11)
        irq_pend = 8'b1000_1000;
        load(16'h4321, 8'h9A, 8'hBC, 8'h00, 16'h0040);
        chk(req_idx == 3'd3, "R10 pick among two", req_idx, 3);
        do_entry(1'b1, 1'b0);
        chk(svc_idx == 3'd3, "R11 entry chosen, svc captured", svc_idx, 3);

        irq_pend = 8'h00;
        load(m_pc, m_x, m_a, 8'h00, m_sp);
        chk(req_valid == 1'b0, "R10 none pending", req_valid, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule